// File: doc/BRIEF.md
# Capture, Compare and PWM Channel

This block is one timer-linked channel that can work in three ways. In capture mode it watches a synchronised input pin. On a chosen edge, or on every 4th or 16th rising edge, it stores the value of a free-running 16-bit timer in its data register and raises an interrupt flag. In compare mode it watches the same timer. When the timer reaches the value in the data register, it raises the flag. Depending on the mode, it can also drive the output pin high, drive it low, or emit a single-cycle special-event pulse.

In PWM mode the output pin produces a waveform whose period is set by an external 8-bit period timer. The duty value is 10 bits wide. Its upper 8 bits come from the low data byte and its lower 2 bits come from control bits 5:4. The output goes high at every period match and goes low when a 10-bit count reaches the duty value. The count is the period timer with its 2 prescale bits appended.

Software reaches the channel through three byte-wide write strobes that share one data bus (low data byte, high data byte, control) and through byte-wide readback ports. The timers live outside the block. The channel only consumes their count values and the period-match pulse.

Top module: `ccp_channel`

## Requirements
- R1: After reset both data bytes, the control readback, the interrupt flag, the output pin and the special-event pulse are all 0.
- R2: Control writes store bits 5:0 and read back bits 7:6 as 0. Data byte writes read back unchanged.
- R3: Mode field control[3:0] = 0100 captures on each falling edge of the pin and 0101 on each rising edge. A capture copies the 16-bit timer into the high:low data bytes in the clock edge that sees the edge, and sets the flag.
- R4: Mode 0110 captures only on every 4th rising edge, and mode 0111 only on every 16th.
- R5: The edge prescale count restarts from zero whenever the mode field changes or the unit is off.
- R6: In a compare mode (10xx) the flag is set once when the timer becomes equal to high:low. In mode 1010 the output pin holds its level.
- R7: Writing mode 1000 forces the pin low and a match then drives it high. Writing mode 1001 forces the pin high and a match drives it low.
- R8: In mode 1011 a match also produces a special-event pulse exactly one cycle long, even while the timer stays equal.
- R9: In PWM mode (11xx) the pin goes high at a period match when the duty value is nonzero. It goes low when the 10-bit count equals the duty value. With a duty of 0 the pin stays low.
- R10: The duty value is sampled only at a period match. Writes made during a period take effect at the next match.
- R11: The flag_clr input clears the flag. A capture or compare event in the same cycle wins and leaves it set.
- R12: With mode 0000 no capture or compare takes place, and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the low data byte |
| wr_hi | input | 1 | Write strobe for the high data byte |
| wr_ctl | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data shared by the strobes |
| flag_clr | input | 1 | Clears the interrupt flag |
| timer_val | input | 16 | Free-running timer value |
| period_match | input | 1 | One-cycle pulse at each period-timer match |
| pwm_count | input | 10 | Period timer with its 2 prescale bits appended |
| pin_in | input | 1 | Synchronised capture input |
| data_lo_o | output | 8 | Low data byte readback |
| data_hi_o | output | 8 | High data byte readback |
| ctl_o | output | 8 | Control readback, bits 7:6 zero |
| pin_out | output | 1 | Compare or PWM output pin |
| irq_flag | output | 1 | Interrupt flag |
| special_evt | output | 1 | Single-cycle special-event trigger |

## Verification
The hardest state to reach from the ports is a partly filled edge prescaler that must then be thrown away. The bench selects the 4th-edge mode, gives three rising edges with distinct timer values, and then passes through the off mode, or switches to the 16th-edge mode and back. It then shows that three more edges still leave the data untouched and that only the fourth one captures. The PWM double buffer is handled in a similar way. The low data byte is rewritten in the middle of a period, and the bench checks that the falling point moves only after the following period match.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF      = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_CAP_FALL = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_CAP_RISE = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_CAP_R4   = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_CAP_R16  = 4'b0111;
  localparam logic [MODE_W-1:0] MODE_CMP_HI   = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CMP_LO   = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_CMP_FLAG = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_CMP_EVT  = 4'b1011;

  function automatic logic mode_is_capture(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic mode_is_compare(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic mode_is_pwm(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_edge_capture.sv
module ccp_edge_capture
  import ccp_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic [MODE_W-1:0] mode,
  output logic              cap_evt
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

  logic              pin_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rise, fall, restart;

  always_comb begin
    rise    = pin_in & ~pin_q;
    fall    = ~pin_in & pin_q;
    restart = (mode != mode_q) || !mode_is_capture(mode);
    cap_evt = 1'b0;
    cnt_d   = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else begin
      case (mode)
        MODE_CAP_FALL: cap_evt = fall;
        MODE_CAP_RISE: cap_evt = rise;
        MODE_CAP_R4: begin
          if (rise) begin
            if (cnt_q == FAST_LAST) begin
              cap_evt = 1'b1;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        MODE_CAP_R16: begin
          if (rise) begin
            if (cnt_q == SLOW_LAST) begin
              cap_evt = 1'b1;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: cap_evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      mode_q <= MODE_OFF;
      cnt_q  <= '0;
    end else begin
      pin_q  <= pin_in;
      mode_q <= mode;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/ccp_match.sv
module ccp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] timer,
  input  logic [W-1:0] ref_val,
  output logic         hit
);
  logic equal, seen_q, seen_d;

  always_comb begin
    equal  = (timer == ref_val);
    seen_d = arm & equal;
    hit    = arm & equal & ~seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/ccp_pwm_gen.sv
module ccp_pwm_gen #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             period_hit,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] duty_in,
  output logic             pwm_out
);
  logic [CNT_W-1:0] duty_q;
  logic             duty_ld;
  logic             out_q, out_d;

  always_comb begin
    duty_ld = en & period_hit;
    out_d   = out_q;
    if (!en)                  out_d = 1'b0;
    else if (period_hit)      out_d = (duty_in != '0);
    else if (count == duty_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_ld) duty_q <= duty_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int DUTY_LSB = 2,
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  input  logic [2*BYTE_W-1:0] timer_val,
  input  logic              period_match,
  input  logic [BYTE_W+DUTY_LSB-1:0] pwm_count,
  input  logic              pin_in,
  output logic [BYTE_W-1:0] data_lo_o,
  output logic [BYTE_W-1:0] data_hi_o,
  output logic [BYTE_W-1:0] ctl_o,
  output logic              pin_out,
  output logic              irq_flag,
  output logic              special_evt
);
  localparam int TMR_W  = 2 * BYTE_W;
  localparam int CTL_W  = MODE_W + DUTY_LSB;
  localparam int DUTY_W = BYTE_W + DUTY_LSB;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              flag_q, flag_d;
  logic              cmp_q, cmp_d;
  logic              spec_q, spec_d;
  logic [MODE_W-1:0] mode, new_mode;
  logic              cap_evt, cmp_hit, pwm_wave;
  logic [DUTY_W-1:0] duty_next;
  logic              ctl_unused;

  assign mode       = ctl_q[MODE_W-1:0];
  assign new_mode   = wr_data[MODE_W-1:0];
  assign duty_next  = {lo_q, ctl_q[CTL_W-1:MODE_W]};
  assign ctl_unused = ^wr_data[BYTE_W-1:CTL_W];

  ccp_edge_capture #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode(mode), .cap_evt(cap_evt)
  );

  ccp_match #(.W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .arm(mode_is_compare(mode)),
    .timer(timer_val), .ref_val({hi_q, lo_q}), .hit(cmp_hit)
  );

  ccp_pwm_gen #(.CNT_W(DUTY_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en(mode_is_pwm(mode)),
    .period_hit(period_match), .count(pwm_count),
    .duty_in(duty_next), .pwm_out(pwm_wave)
  );

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (cap_evt) begin
      {hi_d, lo_d} = timer_val;
    end else begin
      if (wr_lo) lo_d = wr_data;
      if (wr_hi) hi_d = wr_data;
    end

    ctl_d = wr_ctl ? wr_data[CTL_W-1:0] : ctl_q;

    if (cap_evt || cmp_hit) flag_d = 1'b1;
    else if (flag_clr)      flag_d = 1'b0;
    else                    flag_d = flag_q;

    cmp_d = cmp_q;
    if (wr_ctl && new_mode == MODE_CMP_HI) cmp_d = 1'b0;
    if (wr_ctl && new_mode == MODE_CMP_LO) cmp_d = 1'b1;
    if (cmp_hit && mode == MODE_CMP_HI)    cmp_d = 1'b1;
    if (cmp_hit && mode == MODE_CMP_LO)    cmp_d = 1'b0;

    spec_d = cmp_hit && (mode == MODE_CMP_EVT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_evt || wr_lo) lo_q <= lo_d;
      if (cap_evt || wr_hi) hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cmp_q  <= 1'b0;
      spec_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      cmp_q  <= cmp_d;
      spec_q <= spec_d;
    end
  end

  assign data_lo_o   = lo_q;
  assign data_hi_o   = hi_q;
  assign ctl_o       = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};
  assign irq_flag    = flag_q;
  assign special_evt = spec_q;
  assign pin_out     = mode_is_pwm(mode)     ? pwm_wave :
                       mode_is_compare(mode) ? cmp_q    : 1'b0;
endmodule

// File: rtl/ccp_channel_sva.sv
module ccp_channel_sva
  import ccp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_ctl,
  input logic        period_match,
  input logic [15:0] timer_val,
  input logic [7:0]  data_lo_o,
  input logic [7:0]  data_hi_o,
  input logic [7:0]  ctl_o,
  input logic        pin_out,
  input logic        irq_flag,
  input logic        special_evt
);
  assert_ctl_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[7:6] == 2'b00);

  assert_capture_copies_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_flag) && mode_is_capture(ctl_o[3:0]) && $past(ctl_o[3:0]) == ctl_o[3:0])
    |-> {data_hi_o, data_lo_o} == $past(timer_val));

  assert_flag_only_holds_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o[3:0] == MODE_CMP_FLAG && !wr_ctl) |=> $stable(pin_out));

  assert_set_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_flag) && ctl_o[3:0] == MODE_CMP_HI && $past(ctl_o[3:0]) == MODE_CMP_HI)
    |-> pin_out);

  assert_special_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    special_evt |=> !special_evt);

  assert_special_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    special_evt |-> irq_flag);

  assert_pwm_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_pwm(ctl_o[3:0]) && !wr_ctl && period_match && {data_lo_o, ctl_o[5:4]} != 10'd0)
    |=> pin_out);

  assert_off_pin_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o[3:0] == MODE_OFF) |-> !pin_out);
endmodule

bind ccp_channel ccp_channel_sva u_sva (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .period_match(period_match),
  .timer_val(timer_val), .data_lo_o(data_lo_o), .data_hi_o(data_hi_o),
  .ctl_o(ctl_o), .pin_out(pin_out), .irq_flag(irq_flag), .special_evt(special_evt)
);

// File: tb/ccp_channel_test.sv
module ccp_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0, wr_ctl = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        flag_clr = 1'b0;
  logic [15:0] timer_val = 16'h0000;
  logic        period_match = 1'b0;
  logic [9:0]  pwm_count = 10'd0;
  logic        pin_in = 1'b0;
  logic [7:0]  data_lo_o, data_hi_o, ctl_o;
  logic        pin_out, irq_flag, special_evt;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ccp_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .flag_clr(flag_clr), .timer_val(timer_val),
    .period_match(period_match), .pwm_count(pwm_count), .pin_in(pin_in),
    .data_lo_o(data_lo_o), .data_hi_o(data_hi_o), .ctl_o(ctl_o),
    .pin_out(pin_out), .irq_flag(irq_flag), .special_evt(special_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_lo(input logic [7:0] v);
    wr_lo = 1'b1; wr_data = v; tick(); wr_lo = 1'b0;
  endtask

  task automatic put_hi(input logic [7:0] v);
    wr_hi = 1'b1; wr_data = v; tick(); wr_hi = 1'b0;
  endtask

  task automatic put_ctl(input logic [7:0] v);
    wr_ctl = 1'b1; wr_data = v; tick(); wr_ctl = 1'b0; tick();
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic rise_pulse(input logic [15:0] t);
    pin_in = 1'b1; timer_val = t; tick();
    pin_in = 1'b0; tick();
  endtask

  task automatic test_reset();
    chk("R1 data_lo", data_lo_o, 0);
    chk("R1 data_hi", data_hi_o, 0);
    chk("R1 ctl", ctl_o, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 pin", pin_out, 0);
    chk("R1 special", special_evt, 0);
  endtask

  task automatic test_regs();
    put_lo(8'hA5); put_hi(8'h3C);
    chk("R2 lo readback", data_lo_o, 8'hA5);
    chk("R2 hi readback", data_hi_o, 8'h3C);
    put_ctl(8'hF3);
    chk("R2 ctl top bits zero", ctl_o, 8'h33);
    put_ctl(8'h00);
  endtask

  task automatic test_edge_capture();
    put_ctl(8'h05);
    rise_pulse(16'h1234);
    chk("R3 rising capture", {data_hi_o, data_lo_o}, 16'h1234);
    chk("R3 rising flag", irq_flag, 1);
    clear_flag();
    chk("R11 flag cleared", irq_flag, 0);
    put_ctl(8'h04);
    pin_in = 1'b1; timer_val = 16'h1111; tick();
    chk("R3 no capture on rise in falling mode", irq_flag, 0);
    pin_in = 1'b0; timer_val = 16'hBEEF; tick();
    chk("R3 falling capture", {data_hi_o, data_lo_o}, 16'hBEEF);
    chk("R3 falling flag", irq_flag, 1);
    clear_flag();
  endtask

  task automatic test_prescale();
    put_ctl(8'h06);
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0100 + 16'(i));
    chk("R4 no capture before 4th", irq_flag, 0);
    rise_pulse(16'h0404);
    chk("R4 4th edge capture", {data_hi_o, data_lo_o}, 16'h0404);
    clear_flag();
    put_ctl(8'h07);
    for (int i = 1; i <= 15; i++) rise_pulse(16'h0700 + 16'(i));
    chk("R4 no capture before 16th", irq_flag, 0);
    rise_pulse(16'h1616);
    chk("R4 16th edge capture", {data_hi_o, data_lo_o}, 16'h1616);
    clear_flag();
    put_ctl(8'h06);
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0200 + 16'(i));
    put_ctl(8'h00);
    put_ctl(8'h06);
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0300 + 16'(i));
    chk("R5 off clears prescale", irq_flag, 0);
    rise_pulse(16'h0A0A);
    chk("R5 capture after restart", {data_hi_o, data_lo_o}, 16'h0A0A);
    clear_flag();
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0500 + 16'(i));
    put_ctl(8'h07);
    put_ctl(8'h06);
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0600 + 16'(i));
    chk("R5 mode change clears prescale", irq_flag, 0);
    rise_pulse(16'h0B0B);
    chk("R5 capture after mode change", {data_hi_o, data_lo_o}, 16'h0B0B);
    clear_flag();
  endtask

  task automatic test_flag_priority();
    put_ctl(8'h05);
    pin_in = 1'b1; timer_val = 16'h2222; flag_clr = 1'b1; tick();
    flag_clr = 1'b0; pin_in = 1'b0; tick();
    chk("R11 event wins over clear", irq_flag, 1);
    clear_flag();
  endtask

  task automatic test_compare();
    timer_val = 16'h0000;
    put_lo(8'h34); put_hi(8'h12);
    put_ctl(8'h08);
    chk("R7 set mode starts low", pin_out, 0);
    timer_val = 16'h1233; tick();
    chk("R6 no flag before match", irq_flag, 0);
    timer_val = 16'h1234; tick();
    chk("R6 flag on match", irq_flag, 1);
    chk("R7 pin driven high", pin_out, 1);
    timer_val = 16'h0000; clear_flag();
    put_ctl(8'h09);
    chk("R7 clear mode starts high", pin_out, 1);
    timer_val = 16'h1234; tick();
    chk("R7 pin driven low", pin_out, 0);
    timer_val = 16'h0000; clear_flag();
    put_ctl(8'h0A);
    timer_val = 16'h1234; tick();
    chk("R6 flag-only mode flags", irq_flag, 1);
    chk("R6 flag-only mode holds pin", pin_out, 0);
    chk("R8 no pulse in flag-only mode", special_evt, 0);
    timer_val = 16'h0000; clear_flag();
    put_ctl(8'h0B);
    timer_val = 16'h1234; tick();
    chk("R8 special pulse", special_evt, 1);
    tick();
    chk("R8 pulse one cycle", special_evt, 0);
    clear_flag();
    chk("R6 no second flag while equal", irq_flag, 0);
    timer_val = 16'h0000;
    put_ctl(8'h00);
  endtask

  task automatic test_off();
    timer_val = 16'h1234; tick();
    rise_pulse(16'h5555);
    chk("R12 no event when off", irq_flag, 0);
    chk("R12 data unchanged when off", {data_hi_o, data_lo_o}, 16'h1234);
    chk("R12 pin low when off", pin_out, 0);
    timer_val = 16'h0000;
  endtask

  task automatic run_period(input int fall_at, input logic [7:0] mid_lo, input bit do_mid,
                            input string tag);
    period_match = 1'b1; pwm_count = 10'd0; tick();
    period_match = 1'b0;
    chk({tag, " high after period match"}, pin_out, 1);
    for (int c = 1; c < fall_at; c++) begin
      pwm_count = 10'(c);
      if (do_mid && c == 3) begin
        wr_lo = 1'b1; wr_data = mid_lo;
      end
      tick();
      wr_lo = 1'b0;
    end
    chk({tag, " high before duty"}, pin_out, 1);
    pwm_count = 10'(fall_at); tick();
    chk({tag, " low at duty"}, pin_out, 0);
  endtask

  task automatic test_pwm();
    put_lo(8'h02);
    put_ctl(8'h1C);
    chk("R9 pwm low before first match", pin_out, 0);
    run_period(9, 8'h05, 1'b1, "R10 duty buffered");
    run_period(21, 8'h00, 1'b0, "R9 new duty");
    put_lo(8'h00);
    put_ctl(8'h0C);
    period_match = 1'b1; pwm_count = 10'd0; tick();
    period_match = 1'b0;
    chk("R9 zero duty stays low", pin_out, 0);
    put_ctl(8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    test_reset();
    test_regs();
    test_edge_capture();
    test_prescale();
    test_flag_priority();
    test_compare();
    test_off();
    test_pwm();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule